// File: doc/BRIEF.md
# Programmable Buzzer Tone Generator

This peripheral turns a 12 or 13 MHz reference clock into a square-wave buzzer tone. Software programs it through three 32-bit registers on a simple register bus. The first is a level register that is stored and read back. The second is a voice register that holds the enable, the octave field and four ratio selects. The third is a global register that holds the pre-divider select.

The pitch comes from a chain of dividers. A fixed divide-by-8 stage comes first. Next is a pre-divider that divides by 1 or by 154, then an octave divider that divides by a power of two. After that come four fractional rate stages in cascade. Each stage is an accumulator that passes either all of its input pulses or only a fixed fraction of them. The last pulse train toggles the tone output, so the output is a 50% duty square wave. While the tone is disabled, the whole chain is held at zero. Each enable therefore starts the output with the same phase.

Top module: `tone_gen`

## Requirements
- R1: Reset clears the level, voice and global registers to zero and drives the tone output low.
- R2: Only the low bits of each register are stored: 6 bits at byte offset 0x00 (level), 7 bits at 0x04 (voice) and 2 bits at 0x08 (global). All higher read-data bits return zero.
- R3: Only accesses with all four byte enables high take effect. A read of any other offset, or a read with partial byte enables, returns 0. A write to any other offset, or with partial byte enables, leaves all registers unchanged.
- R4: While voice bit 0 is clear, the tone output is low and every divider stage is held at zero.
- R5: The input clock is divided by 8. Global bit 1 set makes the pre-divider pass every pulse. Global bit 1 clear makes it divide by 154.
- R6: Voice bits [1:0] set the octave divider to 2 << bits. Bit 0 is also the enable, so while the tone sounds the divider is 4 (bits = 01) or 16 (bits = 11).
- R7: Four fractional stages follow, in order of voice bits 2, 3, 4 and 5, with denominators 107, 55, 63 and 127. A set bit passes 101, 49, 50 or 80 of every D pulses respectively. A clear bit passes every pulse. After M octave pulses counted from an enable, each stage has emitted floor(input count × N / D) pulses.
- R8: Every pulse that leaves the last stage toggles the tone output. After an enable write, with the pre-divider bypassed and the octave at 4, the first rising edge of the tone comes exactly 32 clocks after the write edge.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Reference clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_cs | input | 1 | Access strobe, one cycle per access |
| bus_we | input | 1 | 1 = write, 0 = read |
| bus_be | input | 4 | Byte enables; only 4'hF is a valid access |
| bus_addr | input | ADDR_W | Byte offset within the block |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data, valid in the same cycle as the read strobe |
| tone_o | output | 1 | Square-wave tone output |

## Verification
The assertions assume that reset is held low from time zero until at least the first clock edge. They also assume that a write lasts exactly one strobed cycle. The minimum half-period property assumes that software changes the octave and pre-divider settings only while the tone is off, because a mid-tone change could bend one period. The bench follows these rules: it writes the voice register to zero before it touches the global register or a new voice value. Every stimulus change is driven on the falling clock edge.

// File: rtl/tone_pkg.sv
package tone_pkg;
    localparam int DATA_W      = 32;
    localparam int LEVEL_W     = 6;
    localparam int VOICE_W     = 7;
    localparam int GLOBAL_W    = 2;
    localparam int OFF_LEVEL   = 0;
    localparam int OFF_VOICE   = 4;
    localparam int OFF_GLOBAL  = 8;
    localparam int PRESCALE    = 8;
    localparam int SLOW_DIV    = 154;
    localparam int OCT_SEL_W   = 2;
    localparam int NUM_FRAC    = 4;
    localparam int FRAC_LSB    = 2;
    localparam int FAST_BIT    = 1;
    localparam int EN_BIT      = 0;
    localparam int USED_VOICE  = FRAC_LSB + NUM_FRAC;
    localparam int FRAC_DEN [NUM_FRAC] = '{107, 55, 63, 127};
    localparam int FRAC_LOW [NUM_FRAC] = '{101, 49, 50, 80};
endpackage

// File: rtl/tone_regs.sv
module tone_regs
    import tone_pkg::*;
#(
    parameter int ADDR_W = 11
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  cs,
    input  logic                  we,
    input  logic [3:0]            be,
    input  logic [ADDR_W-1:0]     addr,
    input  logic [VOICE_W-1:0]    wdata,
    output logic [DATA_W-1:0]     rdata,
    output logic [USED_VOICE-1:0] voice_use,
    output logic                  fast_sel
);
    typedef struct packed {
        logic [LEVEL_W-1:0]  level;
        logic [VOICE_W-1:0]  voice;
        logic [GLOBAL_W-1:0] glob;
    } regs_t;

    regs_t r_q, r_d;
    logic  full_acc, hit_level, hit_voice, hit_glob;

    always_comb begin
        full_acc  = cs && (be == 4'hF);
        hit_level = full_acc && (addr == ADDR_W'(OFF_LEVEL));
        hit_voice = full_acc && (addr == ADDR_W'(OFF_VOICE));
        hit_glob  = full_acc && (addr == ADDR_W'(OFF_GLOBAL));

        r_d = r_q;
        if (we) begin
            if (hit_level) r_d.level = wdata[LEVEL_W-1:0];
            if (hit_voice) r_d.voice = wdata[VOICE_W-1:0];
            if (hit_glob)  r_d.glob  = wdata[GLOBAL_W-1:0];
        end

        rdata = '0;
        if (!we) begin
            if (hit_level) rdata[LEVEL_W-1:0]  = r_q.level;
            if (hit_voice) rdata[VOICE_W-1:0]  = r_q.voice;
            if (hit_glob)  rdata[GLOBAL_W-1:0] = r_q.glob;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) r_q <= '0;
        else        r_q <= r_d;
    end

    assign voice_use = r_q.voice[USED_VOICE-1:0];
    assign fast_sel  = r_q.glob[FAST_BIT];
endmodule

// File: rtl/tone_frac_stage.sv
module tone_frac_stage #(
    parameter int DEN = 107,
    parameter int LOW = 101
) (
    input  logic clk,
    input  logic rst_n,
    input  logic clear,
    input  logic sel_low,
    input  logic pulse_i,
    output logic pulse_o
);
    localparam int ACC_W = $clog2(2 * DEN);

    typedef struct packed {
        logic [ACC_W-1:0] acc;
    } stage_t;

    stage_t           s_q, s_d;
    logic [ACC_W-1:0] step, sum;

    always_comb begin
        step    = sel_low ? ACC_W'(LOW) : ACC_W'(DEN);
        sum     = s_q.acc + step;
        pulse_o = pulse_i && (sum >= ACC_W'(DEN));
        s_d     = s_q;
        if (clear)        s_d.acc = '0;
        else if (pulse_i) s_d.acc = pulse_o ? (sum - ACC_W'(DEN)) : sum;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) s_q <= '0;
        else        s_q <= s_d;
    end
endmodule

// File: rtl/tone_gen.sv
module tone_gen
    import tone_pkg::*;
#(
    parameter int ADDR_W = 11
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              bus_cs,
    input  logic              bus_we,
    input  logic [3:0]        bus_be,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic [DATA_W-1:0] bus_wdata,
    output logic [DATA_W-1:0] bus_rdata,
    output logic              tone_o
);
    localparam int PRE_W  = $clog2(PRESCALE);
    localparam int SLOW_W = $clog2(SLOW_DIV);
    localparam int OCT_W  = $clog2(2 << ((1 << OCT_SEL_W) - 1));

    typedef struct packed {
        logic [PRE_W-1:0]  pre;
        logic [SLOW_W-1:0] slow;
        logic [OCT_W-1:0]  oct;
        logic              tone;
    } chain_t;

    chain_t                c_q, c_d;
    logic [USED_VOICE-1:0] voice_use;
    logic                  fast_sel, en;
    logic                  tick_pre, tick_slow, tick_oct, final_pulse;
    logic [OCT_W:0]        oct_div;
    logic                  unused_wdata;

    assign unused_wdata = ^bus_wdata[DATA_W-1:VOICE_W];

    tone_regs #(.ADDR_W(ADDR_W)) u_regs (
        .clk       (clk),
        .rst_n     (rst_n),
        .cs        (bus_cs),
        .we        (bus_we),
        .be        (bus_be),
        .addr      (bus_addr),
        .wdata     (bus_wdata[VOICE_W-1:0]),
        .rdata     (bus_rdata),
        .voice_use (voice_use),
        .fast_sel  (fast_sel)
    );

    assign en        = voice_use[EN_BIT];
    assign oct_div   = (OCT_W+1)'(2) << voice_use[OCT_SEL_W-1:0];
    assign tick_pre  = en && (c_q.pre == PRE_W'(PRESCALE - 1));
    assign tick_slow = tick_pre && (fast_sel || (c_q.slow == SLOW_W'(SLOW_DIV - 1)));
    assign tick_oct  = tick_slow && ({1'b0, c_q.oct} >= (oct_div - 1'b1));

    for (genvar i = 0; i < NUM_FRAC; i++) begin : g_frac
        logic stage_in, stage_out;
        if (i == 0) begin : g_head
            assign stage_in = tick_oct;
        end else begin : g_link
            assign stage_in = g_frac[i-1].stage_out;
        end
        tone_frac_stage #(.DEN(FRAC_DEN[i]), .LOW(FRAC_LOW[i])) u_stage (
            .clk     (clk),
            .rst_n   (rst_n),
            .clear   (!en),
            .sel_low (voice_use[FRAC_LSB + i]),
            .pulse_i (stage_in),
            .pulse_o (stage_out)
        );
    end

    assign final_pulse = g_frac[NUM_FRAC-1].stage_out;

    always_comb begin
        c_d = c_q;
        if (!en) begin
            c_d = '0;
        end else begin
            c_d.pre = tick_pre ? '0 : c_q.pre + 1'b1;
            if (tick_pre && !fast_sel)
                c_d.slow = (c_q.slow == SLOW_W'(SLOW_DIV - 1)) ? '0 : c_q.slow + 1'b1;
            if (tick_slow)
                c_d.oct = tick_oct ? '0 : c_q.oct + 1'b1;
            if (final_pulse)
                c_d.tone = !c_q.tone;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) c_q <= '0;
        else        c_q <= c_d;
    end

    assign tone_o = c_q.tone;
endmodule

// File: rtl/tone_gen_chk.sv
module tone_gen_chk
    import tone_pkg::*;
#(
    parameter int ADDR_W = 11
) (
    input logic                  clk,
    input logic                  rst_n,
    input logic                  cs,
    input logic                  we,
    input logic [3:0]            be,
    input logic [ADDR_W-1:0]     addr,
    input logic [DATA_W-1:0]     rdata,
    input logic [USED_VOICE-1:0] voice_use,
    input logic                  fast_sel,
    input logic                  tone
);
    localparam int MIN_HALF = PRESCALE * 4;
    localparam int GAP_W    = $clog2(MIN_HALF) + 2;

    logic             tone_prev, decoded;
    logic [GAP_W-1:0] gap;

    assign decoded = (addr == ADDR_W'(OFF_LEVEL)) || (addr == ADDR_W'(OFF_VOICE))
                  || (addr == ADDR_W'(OFF_GLOBAL));

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            tone_prev <= 1'b0;
            gap       <= '0;
        end else begin
            tone_prev <= tone;
            if (!voice_use[EN_BIT] || (tone != tone_prev)) gap <= GAP_W'(1);
            else if (gap != '1)                             gap <= gap + 1'b1;
        end
    end

    // R1: the cycle after reset is seen, everything is cleared
    p_reset_clear_r1: assert property (@(posedge clk)
        !rst_n |=> (voice_use == '0) && !fast_sel && !tone);

    // R2: bits above the widest register never read as one
    p_rdata_upper_r2: assert property (@(posedge clk) disable iff (!rst_n)
        rdata[DATA_W-1:VOICE_W] == '0);

    // R3: undecoded or partial reads return zero
    p_undecoded_read_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (cs && !we && (!decoded || be != 4'hF)) |-> rdata == '0);

    // R3: a partial write leaves the used settings alone
    p_partial_write_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (cs && we && be != 4'hF) |=> ($stable(voice_use) && $stable(fast_sel)));

    // R4: disabled tone is low one cycle later
    p_silent_r4: assert property (@(posedge clk) disable iff (!rst_n)
        !voice_use[EN_BIT] |=> !tone);

    // R8: while sounding, no half period is shorter than the fastest chain
    p_min_half_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (voice_use[EN_BIT] && tone != tone_prev) |-> gap >= GAP_W'(MIN_HALF));
endmodule

bind tone_gen tone_gen_chk #(.ADDR_W(ADDR_W)) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .cs        (bus_cs),
    .we        (bus_we),
    .be        (bus_be),
    .addr      (bus_addr),
    .rdata     (bus_rdata),
    .voice_use (voice_use),
    .fast_sel  (fast_sel),
    .tone      (tone_o)
);

// File: tb/tone_gen_test.sv
`timescale 1ns/1ps
module tone_gen_test;
    localparam int AW = 11;
    localparam logic [AW-1:0] A_LEVEL = 11'h000;
    localparam logic [AW-1:0] A_VOICE = 11'h004;
    localparam logic [AW-1:0] A_GLOB  = 11'h008;
    // {global, voice, octave pulses M}
    localparam int NV = 8;
    localparam logic [31:0] VECS [NV] = '{
        {8'h02, 8'h01, 16'd20},
        {8'h02, 8'h03, 16'd10},
        {8'h02, 8'h05, 16'd214},
        {8'h02, 8'h09, 16'd110},
        {8'h02, 8'h11, 16'd126},
        {8'h02, 8'h3D, 16'd300},
        {8'h00, 8'h01, 16'd4},
        {8'h02, 8'h23, 16'd127}
    };

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        cs = 1'b0, we = 1'b0;
    logic [3:0]  be = 4'hF;
    logic [AW-1:0] addr = '0;
    logic [31:0] wdata = '0;
    logic [31:0] rdata;
    logic        tone;
    int          checks = 0, fails = 0;
    bit          done = 1'b0;

    always #2.5 clk = ~clk;

    tone_gen #(.ADDR_W(AW)) uut (
        .clk(clk), .rst_n(rst_n), .bus_cs(cs), .bus_we(we), .bus_be(be),
        .bus_addr(addr), .bus_wdata(wdata), .bus_rdata(rdata), .tone_o(tone)
    );

    task automatic chk(input string tag, input longint act, input longint exp);
        checks++;
        if (act != exp) begin
            fails++;
            $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    task automatic wr(input logic [AW-1:0] a, input logic [31:0] d, input logic [3:0] b);
        @(negedge clk);
        cs = 1'b1; we = 1'b1; addr = a; wdata = d; be = b;
        @(negedge clk);
        cs = 1'b0; we = 1'b0; be = 4'hF;
    endtask

    task automatic rd(input logic [AW-1:0] a, input logic [3:0] b, output logic [31:0] d);
        @(negedge clk);
        cs = 1'b1; we = 1'b0; addr = a; be = b;
        #1 d = rdata;
        cs = 1'b0; be = 4'hF;
    endtask

    function automatic int expect_toggles(input logic [7:0] v, input int m);
        int den [4] = '{107, 55, 63, 127};
        int low [4] = '{101, 49, 50, 80};
        int n = m;
        for (int i = 0; i < 4; i++)
            if (v[2+i]) n = (n * low[i]) / den[i];
        return n;
    endfunction

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            fails++;
            checks++;
            $display("FAIL watchdog expired");
            $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
            $finish;
        end
    end

    initial begin
        logic [31:0] d;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;

        // R1: reset state
        rd(A_LEVEL, 4'hF, d); chk("R1 level", d, 0);
        rd(A_VOICE, 4'hF, d); chk("R1 voice", d, 0);
        rd(A_GLOB,  4'hF, d); chk("R1 global", d, 0);
        chk("R1 tone", tone, 0);

        // R2: stored widths
        wr(A_LEVEL, 32'hFFFF_FFFF, 4'hF); rd(A_LEVEL, 4'hF, d); chk("R2 level mask", d, 32'h3F);
        wr(A_GLOB,  32'hFFFF_FFFF, 4'hF); rd(A_GLOB,  4'hF, d); chk("R2 global mask", d, 32'h3);
        wr(A_VOICE, 32'hFFFF_FF80, 4'hF); rd(A_VOICE, 4'hF, d); chk("R2 voice mask", d, 0);
        wr(A_VOICE, 32'hFFFF_FFFE, 4'hF); rd(A_VOICE, 4'hF, d); chk("R2 voice bits", d, 32'h7E);

        // R3: undecoded offset and partial access
        rd(11'h00C, 4'hF, d); chk("R3 undecoded read", d, 0);
        rd(11'h002, 4'hF, d); chk("R3 unaligned read", d, 0);
        rd(A_LEVEL, 4'h1, d); chk("R3 partial read", d, 0);
        wr(11'h00C, 32'h0, 4'hF);
        wr(A_LEVEL, 32'h0, 4'h3);
        wr(A_GLOB,  32'h0, 4'h1);
        rd(A_LEVEL, 4'hF, d); chk("R3 level kept", d, 32'h3F);
        rd(A_GLOB,  4'hF, d); chk("R3 global kept", d, 32'h3);
        rd(A_VOICE, 4'hF, d); chk("R3 voice kept", d, 32'h7E);

        // R5 R6 R7: toggle counts over exact windows
        for (int k = 0; k < NV; k++) begin
            logic [7:0] g, v;
            int m, per, len, cnt;
            logic prev;
            g = VECS[k][31:24]; v = VECS[k][23:16]; m = int'(VECS[k][15:0]);
            per = 8 * (g[1] ? 1 : 154) * (2 << v[1:0]);
            len = m * per;
            wr(A_VOICE, 32'h0, 4'hF);
            wr(A_GLOB, {24'h0, g}, 4'hF);
            wr(A_VOICE, {24'h0, v}, 4'hF);
            prev = tone; cnt = 0;
            for (int c = 0; c < len; c++) begin
                @(posedge clk); @(negedge clk);
                if (tone != prev) cnt++;
                prev = tone;
            end
            chk($sformatf("R5 R6 R7 vector %0d toggles", k), cnt, expect_toggles(v, m));
        end

        // R4: disable forces low and holds it
        begin
            int highs = 0;
            wr(A_VOICE, 32'h0, 4'hF);
            @(negedge clk);
            for (int c = 0; c < 200; c++) begin
                @(negedge clk);
                if (tone) highs++;
            end
            chk("R4 silent while disabled", highs, 0);
        end

        // R8: deterministic first edge after enable
        begin
            logic at31, at32;
            wr(A_GLOB, 32'h2, 4'hF);
            wr(A_VOICE, 32'h1, 4'hF);
            for (int c = 1; c <= 32; c++) begin
                @(posedge clk); @(negedge clk);
                if (c == 31) at31 = tone;
                if (c == 32) at32 = tone;
            end
            chk("R8 low before edge 32", at31, 0);
            chk("R8 high at edge 32", at32, 1);
        end

        // R1: reset in the middle of a tone
        wr(A_LEVEL, 32'h15, 4'hF);
        @(negedge clk); rst_n = 1'b0;
        @(negedge clk); chk("R1 tone after reset", tone, 0);
        rst_n = 1'b1;
        rd(A_LEVEL, 4'hF, d); chk("R1 level after reset", d, 0);
        rd(A_VOICE, 4'hF, d); chk("R1 voice after reset", d, 0);
        rd(A_GLOB,  4'hF, d); chk("R1 global after reset", d, 0);

        done = 1'b1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end
endmodule